// File: doc/BRIEF.md
# Programmable IDE PIO Cycle Timer

This block times one programmed-I/O transfer on an IDE bus. A requester offers a transfer on a valid/ready handshake, carrying the direction (read or write) and whether the target is the data port or the command/control register group. On acceptance the block picks one of two 8-bit timing bytes, locks it in, and walks through three phases counted in bus clocks. In the address setup phase the cycle is marked active and both strobes are high. In the active phase the read or write strobe is low. In the hold phase the strobes are high again. A one-clock completion pulse follows the last hold clock.

Each timing byte packs three codes. The two top bits give the setup length. A 3-bit code in the middle gives the hold length, and a 3-bit code at the bottom gives the active length. Both 3-bit codes map onto non-linear tables, so long cycles need no wide fields. When the ready-stretch enable is set, the drive can lengthen the active phase by holding its ready line low. The requester must keep `req_valid` and its fields stable until `req_ready` is high at a rising edge. `req_ready` is high only while no cycle is in progress, which includes the clock that carries the completion pulse. Back-to-back transfers therefore lose no clock.

Top module: `pio_cycle_timer`

## Requirements
- R1: `req_ready` is 1 exactly when no cycle is in progress. A transfer is accepted at a rising edge where `req_valid` and `req_ready` are both 1. A `req_valid` presented while busy changes nothing in the cycle in progress.
- R2: Bits 7:6 of the selected timing byte set the setup phase to the field value plus one clocks (1 to 4). The setup phase begins in the clock after acceptance. During setup `cyc_active` is 1 and both strobes are 1.
- R3: Bits 2:0 set the active phase. Codes 0 to 7 give 2, 3, 4, 5, 6, 8, 12 and 16 clocks. During this phase `rd_strobe_n` is 0 for a read (`req_write`=0), or `wr_strobe_n` is 0 for a write (`req_write`=1).
- R4: Bits 5:3 set the hold phase. Codes 0 to 7 give 1, 2, 3, 4, 5, 6, 8 and 12 clocks. During hold `cyc_active` is 1 and both strobes are 1.
- R5: A transfer with `req_cmd_port`=0 takes its timing from `data_timing`. A transfer with `req_cmd_port`=1 takes it from `cmd_timing`. With the usual settings these are 0xF5 and 0xDE.
- R6: When ready-stretch is enabled and `iordy` is 0 at the end of the planned active phase, the active phase continues one clock at a time until `iordy` is sampled as 1. When ready-stretch is disabled, `iordy` has no effect.
- R7: `done` is high for exactly one clock, the clock right after the last hold clock. In that same clock `req_ready` is 1, so a new transfer can be accepted at the end of that clock.
- R8: The timing byte, the direction and the ready-stretch enable are captured at acceptance. Changes to `data_timing`, `cmd_timing` or `iordy_en` during a cycle do not alter that cycle.
- R9: After reset, `cyc_active` and `done` are 0, both strobes are 1 and `req_ready` is 1.
- R10: The two strobes are never low together, and a strobe is low only while `cyc_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_timing | input | 8 | Timing byte for data-port transfers |
| cmd_timing | input | 8 | Timing byte for command/control-port transfers |
| iordy_en | input | 1 | Enables active-phase stretching by `iordy` |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block can accept a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd_port | input | 1 | 1 = command/control port, 0 = data port |
| iordy | input | 1 | Drive ready line, synchronous to `clk` |
| cyc_active | output | 1 | Address valid for the whole cycle |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock completion pulse |

## Verification
Two events can fall in the same clock: the completion pulse of one transfer and the acceptance of the next. The bench provokes this by raising `req_valid` in the very clock that `done` is high. It then checks that the second transfer's setup phase begins in the following clock, with no idle clock in between, and that the first transfer's pulse still lasts exactly one clock. A ready-stretch release that lands on the planned last active clock is also exercised. The case with no stretch (the release in the clock before) is compared against the case with stretch.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
  localparam int TB_W  = 8;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup_m1;
    logic [CNT_W-1:0] active_m1;
    logic [CNT_W-1:0] hold_m1;
  } span_t;

  // active length minus one for each 3-bit code
  function automatic logic [CNT_W-1:0] active_len_m1(input logic [2:0] code);
    case (code)
      3'd0: active_len_m1 = CNT_W'(1);
      3'd1: active_len_m1 = CNT_W'(2);
      3'd2: active_len_m1 = CNT_W'(3);
      3'd3: active_len_m1 = CNT_W'(4);
      3'd4: active_len_m1 = CNT_W'(5);
      3'd5: active_len_m1 = CNT_W'(7);
      3'd6: active_len_m1 = CNT_W'(11);
      default: active_len_m1 = CNT_W'(15);
    endcase
  endfunction

  // hold length minus one for each 3-bit code
  function automatic logic [CNT_W-1:0] hold_len_m1(input logic [2:0] code);
    case (code)
      3'd0: hold_len_m1 = CNT_W'(0);
      3'd1: hold_len_m1 = CNT_W'(1);
      3'd2: hold_len_m1 = CNT_W'(2);
      3'd3: hold_len_m1 = CNT_W'(3);
      3'd4: hold_len_m1 = CNT_W'(4);
      3'd5: hold_len_m1 = CNT_W'(5);
      3'd6: hold_len_m1 = CNT_W'(7);
      default: hold_len_m1 = CNT_W'(11);
    endcase
  endfunction
endpackage

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import pio_timer_pkg::*;
(
  input  logic [TB_W-1:0] tbyte,
  output span_t           span
);
  localparam int SETUP_LSB = TB_W - 2;

  always_comb begin
    span.setup_m1  = CNT_W'(tbyte[TB_W-1:SETUP_LSB]);
    span.hold_m1   = hold_len_m1(tbyte[5:3]);
    span.active_m1 = active_len_m1(tbyte[2:0]);
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_write,
  input  logic       start_stretch,
  input  span_t      start_span,
  input  span_t      run_span,
  input  logic       iordy,
  output phase_e     phase,
  output logic       cur_write,
  output logic       done
);
  logic [CNT_W-1:0] cnt;
  logic             stretch_q;
  logic             hold_off;

  assign hold_off = stretch_q && !iordy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur_write <= 1'b0;
      stretch_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_SETUP;
            cnt       <= start_span.setup_m1;
            cur_write <= start_write;
            stretch_q <= start_stretch;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_ACTIVE;
            cnt   <= run_span.active_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!hold_off) begin
            phase <= PH_HOLD;
            cnt   <= run_span.hold_m1;
          end
        end
        default: begin
          if (cnt == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start) |=> (phase == PH_SETUP));

  assert_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && cnt == '0 && stretch_q && !iordy) |=> (phase == PH_ACTIVE));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_dir_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(cur_write));
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] data_timing,
  input  logic [7:0] cmd_timing,
  input  logic       iordy_en,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       req_cmd_port,
  input  logic       iordy,
  output logic       cyc_active,
  output logic       rd_strobe_n,
  output logic       wr_strobe_n,
  output logic       done
);
  localparam int NUM_DEC = 2;

  logic [TB_W-1:0] live_byte;
  logic [TB_W-1:0] held_byte;
  logic [TB_W-1:0] dec_in [NUM_DEC];
  span_t           dec_out [NUM_DEC];
  logic            accept;
  phase_e          phase;
  logic            cur_write;

  assign live_byte = req_cmd_port ? cmd_timing : data_timing;
  assign accept    = req_valid && req_ready;
  assign dec_in[0] = live_byte;
  assign dec_in[1] = held_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_byte <= '0;
    else if (accept) held_byte <= live_byte;
  end

  // decoder 0 serves the setup load at acceptance, decoder 1 the running cycle
  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    pio_timing_decode u_dec (
      .tbyte (dec_in[g]),
      .span  (dec_out[g])
    );
  end

  pio_phase_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .start_write   (req_write),
    .start_stretch (iordy_en),
    .start_span    (dec_out[0]),
    .run_span      (dec_out[1]),
    .iordy         (iordy),
    .phase         (phase),
    .cur_write     (cur_write),
    .done          (done)
  );

  assign req_ready   = (phase == PH_IDLE);
  assign cyc_active  = (phase != PH_IDLE);
  assign rd_strobe_n = !(phase == PH_ACTIVE && !cur_write);
  assign wr_strobe_n = !(phase == PH_ACTIVE && cur_write);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n));

  assert_strobe_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n || !wr_strobe_n) |-> cyc_active);

  assert_byte_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && $past(cyc_active)) |-> $stable(held_byte));

  assert_busy_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_active |-> !req_ready);
endmodule

// File: tb/test_pio_cycle_timer.sv
`timescale 1ns/1ps
module test_pio_cycle_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data_timing = 8'hF5;
  logic [7:0] cmd_timing = 8'hDE;
  logic       iordy_en = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic       req_cmd_port = 1'b0;
  logic       iordy = 1'b1;
  logic       req_ready, cyc_active, rd_strobe_n, wr_strobe_n, done;
  int         n_checks = 0;
  int         n_fails = 0;

  always #2 clk = ~clk;

  pio_cycle_timer i_pio_cycle_timer (
    .clk(clk), .rst_n(rst_n), .data_timing(data_timing), .cmd_timing(cmd_timing),
    .iordy_en(iordy_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cmd_port(req_cmd_port), .iordy(iordy),
    .cyc_active(cyc_active), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .done(done)
  );

  function automatic int act_clocks(input logic [2:0] c);
    int t[8] = '{2, 3, 4, 5, 6, 8, 12, 16};
    return t[c];
  endfunction

  function automatic int hold_clocks(input logic [2:0] c);
    int t[8] = '{1, 2, 3, 4, 5, 6, 8, 12};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: outputs {act,rd_n,wr_n,done,rdy} got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {cyc_active, rd_strobe_n, wr_strobe_n, done, req_ready};
  endfunction

  // call at a negedge; returns at the negedge of the completion clock
  task automatic run_cycle(input logic w, input logic c, input int ext, input bit noise,
                           input bit mutate, input string tag);
    logic [7:0] b = c ? cmd_timing : data_timing;
    int s = int'(b[7:6]) + 1;
    int a = act_clocks(b[2:0]);
    int h = hold_clocks(b[5:3]);
    int ae = a + (iordy_en ? ext : 0);
    logic [4:0] e;
    string rq;
    if (ext > 0) iordy = 1'b0;
    req_valid = 1'b1; req_write = w; req_cmd_port = c;
    check(req_ready === 1'b1, {"R1 ", tag}, outs(), 5'b01101);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (mutate) begin
      data_timing = 8'($urandom); cmd_timing = 8'($urandom); iordy_en = 1'($urandom);
    end
    for (int k = 0; k < s + ae + h; k++) begin
      if (k < s) begin e = 5'b11100; rq = "R2"; end
      else if (k < s + ae) begin e = w ? 5'b11000 : 5'b10100; rq = (ext > 0) ? "R6/R3" : "R3"; end
      else begin e = 5'b11100; rq = "R4"; end
      if (mutate) rq = {rq, " R8"};
      check(outs() === e, {rq, " ", tag}, outs(), e);
      check(!(!rd_strobe_n && !wr_strobe_n), {"R10 ", tag}, outs(), e);
      if (noise && k == 1) begin req_valid = 1'b1; req_write = ~w; req_cmd_port = ~c; end
      if (noise && k == 2) req_valid = 1'b0;
      if (ext > 0 && k == s + a - 1 + ext) iordy = 1'b1;
      @(negedge clk);
    end
    iordy = 1'b1;
    check(outs() === 5'b01111, {"R7 ", tag}, outs(), 5'b01111);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(outs() === 5'b01101, "R7 idle after done", outs(), 5'b01101);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #1;
    check(outs() === 5'b01101, "R9 during reset", outs(), 5'b01101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(outs() === 5'b01101, "R9 after reset", outs(), 5'b01101);

    run_cycle(1'b0, 1'b0, 0, 0, 0, "R5 data read default");
    idle(2);
    run_cycle(1'b1, 1'b1, 0, 0, 0, "R5 cmd write default");
    idle(1);
    data_timing = 8'h09;
    run_cycle(1'b0, 1'b0, 0, 0, 0, "R5 data 0x09");
    idle(1);
    data_timing = 8'h00;
    run_cycle(1'b1, 1'b0, 0, 0, 0, "R5 data 0x00");
    idle(1);
    for (int c = 0; c < 8; c++) begin
      data_timing = {2'(c), 3'(c), 3'(c)};
      run_cycle(1'(c), 1'b0, 0, 0, 0, "R2 R3 R4 code sweep");
      idle(1);
    end
    data_timing = 8'h41;
    iordy_en = 1'b1;
    run_cycle(1'b0, 1'b0, 3, 0, 0, "R6 stretch by 3");
    idle(1);
    run_cycle(1'b1, 1'b0, 1, 0, 0, "R6 stretch by 1");
    idle(1);
    iordy_en = 1'b0;
    run_cycle(1'b0, 1'b0, 3, 0, 0, "R6 stretch disabled");
    idle(1);
    run_cycle(1'b0, 1'b1, 0, 1, 0, "R1 request while busy");
    run_cycle(1'b1, 1'b0, 0, 0, 0, "R7 back-to-back");
    run_cycle(1'b0, 1'b1, 0, 0, 1, "R8 change during cycle");
    idle(1);
    for (int r = 0; r < 40; r++) begin
      data_timing = 8'($urandom); cmd_timing = 8'($urandom); iordy_en = 1'($urandom);
      run_cycle(1'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom), 1'($urandom),
                "random");
      if ($urandom % 2 == 0) idle(1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule